// File: doc/BRIEF.md
# Job Result Store and Responder

This is the last stage of a streaming filter pipeline that runs in batches. Once a batch is started, the stage takes command records one at a time from a command stream. For each valid job it moves that job's filtered samples from a data stream onto a simple memory write port. The samples go to consecutive addresses starting at the job's base address. The port marks the end of each group of up to `CHUNK` words, so a downstream burst engine can issue one burst per group. After the last write of a job is accepted, the stage emits one response word on a response stream. The response carries the job's transaction id and its status.

A job flagged as badly sized causes no memory writes and takes nothing from the data stream, but it still produces a response with the error status. The jobs that follow it run normally, because an error affects only its own job. An END record closes the batch. The block waits until the upstream stages report that they have exited, then pulses `done` for one cycle and returns to idle. A new `start` then runs the next batch from a clean state.

All streams are valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. A producer that raises valid must hold it, together with its payload, until the transfer. The block stalls without losing data when `mem_wready` or `rsp_ready` is low. It raises `cmd_ready` only when it can take the next command. It raises `dat_ready` only while a valid job is writing and the memory port is ready.

Top module: `job_result_store`

## Requirements
- R1: After reset, `busy`, `done`, `cmd_ready`, `dat_ready`, `mem_wvalid` and `rsp_valid` are all 0.
- R2: While idle (`busy`=0), no command or data is accepted, whatever the stream inputs do. A `start` pulse while idle sets `busy`.
- R3: A valid job with length L>0 and base address B produces exactly L memory writes, to addresses B..B+L-1 in increasing order. Each write carries the data-stream words in the order they arrived.
- R4: `mem_wlast` is 1 on the write at job offset i exactly when (i mod CHUNK)=CHUNK-1 or i=L-1.
- R5: A job with `cmd_bad`=1 causes no memory writes and no data-stream transfers. Its response has status 1.
- R6: Each job yields exactly one response, in job order. `rsp_data[TXW]` is the status (0 OK, 1 BAD_SIZE) and `rsp_data[TXW-1:0]` is the transaction id. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` stay unchanged.
- R7: A job's response is offered only after its last memory write has been accepted, and `rsp_valid` and `mem_wvalid` are never both 1.
- R8: A valid job that follows a bad job writes exactly its own data, at its own addresses.
- R9: After END is accepted, `done` stays 0 and `busy` stays 1 until `upstream_exited` is 1. `done` is then a single-cycle pulse, after which `busy` is 0.
- R10: After `done`, a new `start` runs a further batch with correct writes and responses.
- R11: A valid job with L=0 makes no writes and takes no data, and its response has status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a batch (taken while idle) |
| upstream_exited | input | 1 | Upstream stages have left their loops |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle end-of-batch pulse |
| cmd_valid | input | 1 | Command record valid |
| cmd_ready | output | 1 | Command record accepted |
| cmd_end | input | 1 | Record is the END sentinel |
| cmd_bad | input | 1 | Job failed size validation |
| cmd_txid | input | TXW | Transaction id |
| cmd_base | input | AW | First output address |
| cmd_len | input | LW | Number of output samples |
| dat_valid | input | 1 | Sample valid |
| dat_ready | output | 1 | Sample accepted |
| dat_data | input | DW | Filtered sample |
| mem_wvalid | output | 1 | Write request |
| mem_wready | input | 1 | Write accepted |
| mem_addr | output | AW | Write address |
| mem_wdata | output | DW | Write data |
| mem_wlast | output | 1 | Last word of a chunk |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_data | output | TXW+1 | {status, txid} |

## Verification
The first batch sweeps job lengths 0 to 9 against a chunk size of 4. This covers empty jobs, jobs shorter than one chunk, jobs that fill a chunk exactly, and jobs that span several chunks. Bad jobs are spread through the sweep, so the checks can tell skipped writes and untouched data apart from a stage that halts or stays out of step after an error. Memory and response back-pressure follow repeating patterns, which separates correct stalling from dropped or duplicated transfers. A second batch with the memory always ready follows a held-off `upstream_exited` and a single-cycle `done`, which shows that the block restarts from a clean state.

// File: rtl/jrs_pkg.sv
package jrs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WRITE, S_RESP, S_DRAIN, S_DONE
  } jrs_state_t;

  localparam logic STATUS_OK  = 1'b0;
  localparam logic STATUS_BAD = 1'b1;
endpackage

// File: rtl/jrs_writer.sv
module jrs_writer #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LW    = 12,
  parameter int CHUNK = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          active,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [DW-1:0] dat_data,
  output logic          mem_wvalid,
  input  logic          mem_wready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wlast,
  output logic          job_last
);
  localparam int CW = (CHUNK > 1) ? $clog2(CHUNK) : 1;
  localparam logic [CW-1:0] CHUNK_END = CW'(CHUNK - 1);

  logic [AW-1:0] addr_q;
  logic [LW-1:0] left_q;
  logic [CW-1:0] pos_q;
  logic          hs;
  logic          job_end;

  assign job_end    = (left_q == LW'(1));
  assign mem_wvalid = active && dat_valid;
  assign dat_ready  = active && mem_wready;
  assign hs         = mem_wvalid && mem_wready;
  assign mem_addr   = addr_q;
  assign mem_wdata  = dat_data;
  assign mem_wlast  = job_end || (pos_q == CHUNK_END);
  assign job_last   = hs && job_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
      pos_q  <= '0;
    end else if (load) begin
      addr_q <= base;
      left_q <= len;
      pos_q  <= '0;
    end else if (hs) begin
      addr_q <= addr_q + AW'(1);
      left_q <= left_q - LW'(1);
      pos_q  <= mem_wlast ? '0 : pos_q + CW'(1);
    end
  end

  // independent run counter: words written since the last chunk mark
  logic [LW:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n || load) run_q <= '0;
    else if (hs) run_q <= mem_wlast ? '0 : run_q + (LW+1)'(1);
  end

  p_chunk_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> (run_q < (LW+1)'(CHUNK)));
  p_no_write_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> (left_q != '0));
endmodule

// File: rtl/jrs_ctrl.sv
module jrs_ctrl
  import jrs_pkg::*;
#(
  parameter int TXW = 8,
  parameter int LW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           upstream_exited,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_end,
  input  logic           cmd_bad,
  input  logic [TXW-1:0] cmd_txid,
  input  logic [LW-1:0]  cmd_len,
  input  logic           job_last,
  output logic           load,
  output logic           wr_active,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [TXW:0]   rsp_data,
  output logic           busy,
  output logic           done
);
  jrs_state_t     state_q, state_d;
  logic [TXW-1:0] tx_q;
  logic           bad_q;
  logic           take;

  assign take      = (state_q == S_FETCH) && cmd_valid;
  assign cmd_ready = (state_q == S_FETCH);
  assign load      = take && !cmd_end && !cmd_bad;
  assign wr_active = (state_q == S_WRITE);
  assign rsp_valid = (state_q == S_RESP);
  assign rsp_data  = {bad_q, tx_q};
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start) state_d = S_FETCH;
      S_FETCH: if (cmd_valid) begin
        if (cmd_end)                          state_d = S_DRAIN;
        else if (cmd_bad || cmd_len == '0)    state_d = S_RESP;
        else                                  state_d = S_WRITE;
      end
      S_WRITE: if (job_last) state_d = S_RESP;
      S_RESP:  if (rsp_ready) state_d = S_FETCH;
      S_DRAIN: if (upstream_exited) state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tx_q    <= '0;
      bad_q   <= STATUS_OK;
    end else begin
      state_q <= state_d;
      if (take && !cmd_end) begin
        tx_q  <= cmd_txid;
        bad_q <= cmd_bad ? STATUS_BAD : STATUS_OK;
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  p_drain_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !upstream_exited && !done && !cmd_ready && !wr_active && !rsp_valid)
      |=> !done);
endmodule

// File: rtl/job_result_store.sv
module job_result_store #(
  parameter int TXW   = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LW    = 12,
  parameter int CHUNK = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           upstream_exited,
  output logic           busy,
  output logic           done,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_end,
  input  logic           cmd_bad,
  input  logic [TXW-1:0] cmd_txid,
  input  logic [AW-1:0]  cmd_base,
  input  logic [LW-1:0]  cmd_len,
  input  logic           dat_valid,
  output logic           dat_ready,
  input  logic [DW-1:0]  dat_data,
  output logic           mem_wvalid,
  input  logic           mem_wready,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           mem_wlast,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [TXW:0]   rsp_data
);
  logic load, wr_active, job_last;

  jrs_ctrl #(.TXW(TXW), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .upstream_exited(upstream_exited),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_end(cmd_end),
    .cmd_bad(cmd_bad), .cmd_txid(cmd_txid), .cmd_len(cmd_len),
    .job_last(job_last), .load(load), .wr_active(wr_active),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .done(done)
  );

  jrs_writer #(.AW(AW), .DW(DW), .LW(LW), .CHUNK(CHUNK)) u_writer (
    .clk(clk), .rst_n(rst_n), .load(load), .base(cmd_base), .len(cmd_len),
    .active(wr_active), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_data(dat_data), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wlast(mem_wlast),
    .job_last(job_last)
  );

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_ready && !dat_ready && !mem_wvalid));
  p_rsp_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && mem_wvalid));
  p_bad_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid && cmd_bad && !cmd_end) |=> (rsp_valid && !dat_ready));
endmodule

// File: tb/job_result_store_bench.sv
`timescale 1ns/1ps
module job_result_store_bench;
  localparam int TXW = 8, AW = 16, DW = 32, LW = 12, CHUNK = 4;

  logic clk = 0, rst_n = 0, start = 0, upstream_exited = 0;
  logic busy, done, cmd_ready, dat_ready, mem_wvalid, mem_wlast, rsp_valid;
  logic cmd_valid = 0, cmd_end = 0, cmd_bad = 0, dat_valid = 0;
  logic [TXW-1:0] cmd_txid = 0;
  logic [AW-1:0]  cmd_base = 0, mem_addr;
  logic [LW-1:0]  cmd_len = 0;
  logic [DW-1:0]  dat_data = 0, mem_wdata;
  logic mem_wready = 0, rsp_ready = 0;
  logic [TXW:0] rsp_data;

  always #2.5 clk = ~clk;

  job_result_store #(.TXW(TXW), .AW(AW), .DW(DW), .LW(LW), .CHUNK(CHUNK)) u_job_result_store (
    .clk(clk), .rst_n(rst_n), .start(start), .upstream_exited(upstream_exited),
    .busy(busy), .done(done), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_end(cmd_end), .cmd_bad(cmd_bad), .cmd_txid(cmd_txid), .cmd_base(cmd_base),
    .cmd_len(cmd_len), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_data(dat_data), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wlast(mem_wlast),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, batch = 0;
  bit finished = 0;

  int          ew_tag[$];
  logic [AW-1:0] ew_addr[$];
  logic [DW-1:0] ew_data[$];
  logic        ew_last[$];
  int          er_tag[$];
  logic [TXW:0] er_word[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] sample(int b, int j, int i);
    return DW'(b * 65536 + j * 256 + i) ^ 32'h5A00_0000;
  endfunction

  // back-pressure patterns, changed just after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    mem_wready = (batch == 2) ? 1'b1 : ((cyc % 3) != 0);
    rsp_ready  = ((cyc % 4) != 1);
  end

  // monitor at the falling edge
  always @(negedge clk) if (rst_n) begin
    if (mem_wvalid && mem_wready) begin
      if (ew_tag.size() == 0) chk(0, "R5", "unexpected write addr", mem_addr, 0);
      else begin
        chk(mem_addr == ew_addr[0], "R3", "write address", mem_addr, ew_addr[0]);
        chk(mem_wdata == ew_data[0], "R8", "write data", mem_wdata, ew_data[0]);
        chk(mem_wlast == ew_last[0], "R4", "chunk last flag", mem_wlast, ew_last[0]);
        void'(ew_tag.pop_front()); void'(ew_addr.pop_front());
        void'(ew_data.pop_front()); void'(ew_last.pop_front());
      end
    end
    if (rsp_valid && rsp_ready) begin
      if (er_tag.size() == 0) chk(0, "R6", "unexpected response", rsp_data, 0);
      else begin
        chk(rsp_data == er_word[0], "R6", "response word", rsp_data, er_word[0]);
        chk(ew_tag.size() == 0 || ew_tag[0] > er_tag[0], "R7",
            "writes pending at response", ew_tag.size(), 0);
        void'(er_tag.pop_front()); void'(er_word.pop_front());
      end
    end
  end

  task automatic send_cmd(bit e, bit b, logic [TXW-1:0] tx, logic [AW-1:0] base, logic [LW-1:0] len);
    bit hs;
    cmd_valid = 1; cmd_end = e; cmd_bad = b; cmd_txid = tx; cmd_base = base; cmd_len = len;
    do begin @(negedge clk); hs = cmd_ready; @(posedge clk); #1; end while (!hs);
    cmd_valid = 0;
  endtask

  task automatic send_dat(logic [DW-1:0] d);
    bit hs;
    dat_valid = 1; dat_data = d;
    do begin @(negedge clk); hs = dat_ready; @(posedge clk); #1; end while (!hs);
    dat_valid = 0;
  endtask

  // one batch: njobs jobs; lengths sweep 0..9, every 4th job (offset 2) bad
  task automatic run_batch(int b, int njobs, int gbase);
    for (int j = 0; j < njobs; j++) begin
      int len = j % 10;
      bit bad = (j % 4 == 2);
      logic [TXW-1:0] tx = TXW'(8'h40 + b * 32 + j);
      logic [AW-1:0] base = AW'(b * 4096 + j * 32);
      er_tag.push_back(gbase + j);
      er_word.push_back({bad, tx});
      if (!bad) for (int i = 0; i < len; i++) begin
        ew_tag.push_back(gbase + j);
        ew_addr.push_back(base + AW'(i));
        ew_data.push_back(sample(b, j, i));
        ew_last.push_back((i % CHUNK == CHUNK - 1) || (i == len - 1));
      end
    end
    fork
      begin
        for (int j = 0; j < njobs; j++)
          send_cmd(0, (j % 4 == 2), TXW'(8'h40 + b * 32 + j), AW'(b * 4096 + j * 32),
                   LW'((j % 4 == 2) ? 7 : j % 10));
        send_cmd(1, 0, 0, 0, 0);
      end
      begin
        for (int j = 0; j < njobs; j++)
          if (j % 4 != 2) for (int i = 0; i < j % 10; i++) send_dat(sample(b, j, i));
      end
    join
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk({busy, done, cmd_ready, dat_ready, mem_wvalid, rsp_valid} == 6'b0, "R1",
        "outputs in reset", {busy, done, cmd_ready, dat_ready, mem_wvalid, rsp_valid}, 0);
    @(posedge clk); #1 rst_n = 1;
    // idle: streams offered, nothing taken
    cmd_valid = 1; dat_valid = 1;
    repeat (5) begin
      @(negedge clk);
      chk(!cmd_ready && !dat_ready && !mem_wvalid && !busy, "R2", "idle accepts nothing",
          {cmd_ready, dat_ready, mem_wvalid, busy}, 0);
    end
    @(posedge clk); #1 cmd_valid = 0; dat_valid = 0;
    chk(ew_tag.size() == 0, "R2", "no write before start", ew_tag.size(), 0);

    // batch 1: sweep with back-pressure, upstream held
    batch = 1;
    start = 1; @(posedge clk); #1 start = 0;
    @(negedge clk);
    chk(busy, "R2", "busy after start", busy, 1);
    @(posedge clk); #1;
    run_batch(1, 20, 0);
    repeat (20) begin
      @(negedge clk);
      chk(!done && busy, "R9", "held while upstream running", {done, busy}, 2'b01);
    end
    @(posedge clk); #1 upstream_exited = 1;
    @(negedge clk);
    chk(!done, "R9", "done latency", done, 0);
    @(negedge clk);
    chk(done, "R9", "done pulse", done, 1);
    @(negedge clk);
    chk(!done && !busy, "R9", "single-cycle done", {done, busy}, 0);
    chk(ew_tag.size() == 0 && er_tag.size() == 0, "R6", "batch 1 complete",
        ew_tag.size() + er_tag.size(), 0);

    // batch 2: restart, memory always ready
    @(posedge clk); #1;
    batch = 2;
    start = 1; @(posedge clk); #1 start = 0;
    run_batch(2, 12, 100);
    repeat (4) @(negedge clk);
    chk(!busy, "R10", "second batch finished", busy, 0);
    chk(ew_tag.size() == 0 && er_tag.size() == 0, "R10", "batch 2 complete",
        ew_tag.size() + er_tag.size(), 0);
    chk(1, "R11", "zero-length jobs covered by sweep", 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule